// File: doc/BRIEF.md
# Status Pin Interrupt Pulser

This block owns a single open-drain status line that carries two kinds of information. The first is a static charge indication: the line is pulled low while charging runs and released otherwise. The second is an interrupt notification, sent as a timed pulse. The block also holds two banks of event flags with their mask inputs, plus one sticky global interrupt bit. Fault and supply-status events arrive as single-cycle strobes. Each event always records its flag and sets the global bit. An unmasked event also starts a pulse, unless the global bit is already set.

The pulse is a low interval of a fixed number of time-base ticks, after which the line is released. If the line is being held low for charging when the pulse starts, a released notch of equal length comes first, so the host still sees an edge. When the sequence ends, the line follows the charging level again. Flags for transient events clear when their bank is read. Flags for level-held conditions clear on read only once their condition input has dropped.

Top module: `stat_irq_pulser`

## Requirements
- R1: When no pulse sequence is running, `stat_pull` equals `chg_active`. After reset, `stat_pull` is 0 with `chg_active` low, and all flags and `glb_irq` are 0.
- R2: An unmasked event while `glb_irq` is 0 and `chg_active` is low pulls `stat_pull` high from the next clock edge. The pull lasts until the TICKS_PER_PHASE-th `tick` after that edge, with 16 ticks by default.
- R3: If `chg_active` is high when such a pulse starts, `stat_pull` first drops to 0 for TICKS_PER_PHASE ticks and then goes to 1 for TICKS_PER_PHASE ticks.
- R4: Any event sets its flag bit and `glb_irq` at the next clock edge, whether masked or not. `glb_irq` is already 1 in the cycle the pulse sequence begins. Fault bits: 0 thermal shutdown, 1 input over-voltage, 2 thermal regulation, 3 32 s timer expiry, 4 dead-battery timer expiry, 5 over-temperature recovery, 6 over-voltage recovery, 7 battery absent. Status bits: 0 supply connected, 1 power-OK, 2 validation failed.
- R5: An event whose mask bit is 1 records its flag and `glb_irq` but starts no pulse.
- R6: While `glb_irq` is 1, no new pulse starts. A `rd_glb` strobe clears `glb_irq` at the next edge.
- R7: A `rd_flt` or `rd_sts` strobe clears every transient flag of that bank at the next edge.
- R8: A level-held flag (fault bits 2 and 7, status bit 1 by default) survives a read while its `*_cond` bit is 1. It clears on a read once the `*_cond` bit is 0.
- R9: An event that coincides with a clearing read leaves its flag, or `glb_irq`, set.
- R10: Changes of `chg_active` during a running sequence do not alter `stat_pull`. When the sequence ends, `stat_pull` follows the current `chg_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base strobe, one cycle per tick |
| chg_active | input | 1 | Charging in progress level |
| flt_evt | input | FLT_W | Fault event strobes |
| flt_cond | input | FLT_W | Fault condition levels, used by held bits |
| flt_mask | input | FLT_W | Fault pulse masks, 1 = no pulse |
| sts_evt | input | STS_W | Status event strobes |
| sts_cond | input | STS_W | Status condition levels, used by held bits |
| sts_mask | input | STS_W | Status pulse masks, 1 = no pulse |
| rd_flt | input | 1 | Fault bank read strobe |
| rd_sts | input | 1 | Status bank read strobe |
| rd_glb | input | 1 | Global bit read strobe |
| stat_pull | output | 1 | Pull-down enable for the open-drain line |
| flt_flags | output | FLT_W | Fault flag bank |
| sts_flags | output | STS_W | Status flag bank |
| glb_irq | output | 1 | Sticky global interrupt bit |

## Verification
The assertions take for granted that event and read inputs are already synchronous, single-cycle strobes. They also assume that a held condition level is raised together with or before its event strobe. The stimulus drives every strobe for exactly one cycle away from the clock edge. It raises each `*_cond` bit in the same cycle as its event and holds it until after the read under test. It spaces pulse-triggering events so that each can be observed on its own, apart from the deliberate overlaps that exercise blocking by the global bit.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_NOTCH = 2'd1,
      PH_LOW   = 2'd2
   } pulse_phase_e;

   localparam int unsigned FLT_W_DEF = 8;
   localparam int unsigned STS_W_DEF = 3;
   localparam int unsigned TICKS_DEF = 16;
endpackage

// File: rtl/stat_irq_flag_bank.sv
module stat_irq_flag_bank #(
   parameter int unsigned W    = 8,
   parameter logic [W-1:0] HELD = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] cond,
   input  logic         rd,
   output logic [W-1:0] flags
);
   generate
      if (W < 1) begin : g_bad_width
         $error("stat_irq_flag_bank: W must be at least 1");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         localparam logic KEEP = HELD[i];
         logic hold;
         logic bit_q;
         assign hold = KEEP & cond[i];
         always_ff @(posedge clk) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (evt[i])
               bit_q <= 1'b1;
            else if (rd && !hold)
               bit_q <= 1'b0;
         end
         assign flags[i] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/stat_irq_pulse_seq.sv
module stat_irq_pulse_seq
   import stat_irq_pkg::*;
#(
   parameter int unsigned TICKS = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         start,
   input  logic         chg_active,
   output pulse_phase_e phase,
   output logic         busy
);
   localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   generate
      if (TICKS < 2) begin : g_bad_ticks
         $error("stat_irq_pulse_seq: TICKS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   pulse_phase_e  phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  phase_q <= chg_active ? PH_NOTCH : PH_LOW;
                  cnt_q   <= '0;
               end
            end
            default: begin
               if (tick) begin
                  if (cnt_q == LAST) begin
                     cnt_q   <= '0;
                     phase_q <= (phase_q == PH_NOTCH) ? PH_LOW : PH_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign phase = phase_q;
   assign busy  = (phase_q != PH_IDLE);
endmodule

// File: rtl/stat_irq_pulser.sv
module stat_irq_pulser
   import stat_irq_pkg::*;
#(
   parameter int unsigned FLT_W           = FLT_W_DEF,
   parameter int unsigned STS_W           = STS_W_DEF,
   parameter int unsigned TICKS_PER_PHASE = TICKS_DEF,
   parameter logic [FLT_W-1:0] FLT_HELD   = FLT_W'(8'h84),
   parameter logic [STS_W-1:0] STS_HELD   = STS_W'(3'b010)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             chg_active,
   input  logic [FLT_W-1:0] flt_evt,
   input  logic [FLT_W-1:0] flt_cond,
   input  logic [FLT_W-1:0] flt_mask,
   input  logic [STS_W-1:0] sts_evt,
   input  logic [STS_W-1:0] sts_cond,
   input  logic [STS_W-1:0] sts_mask,
   input  logic             rd_flt,
   input  logic             rd_sts,
   input  logic             rd_glb,
   output logic             stat_pull,
   output logic [FLT_W-1:0] flt_flags,
   output logic [STS_W-1:0] sts_flags,
   output logic             glb_irq
);
   logic         any_evt;
   logic         unmasked_evt;
   logic         seq_start;
   logic         seq_busy;
   logic         glb_q;
   pulse_phase_e seq_phase;

   assign any_evt      = (|flt_evt) | (|sts_evt);
   assign unmasked_evt = (|(flt_evt & ~flt_mask)) | (|(sts_evt & ~sts_mask));
   assign seq_start    = unmasked_evt & ~glb_q;

   stat_irq_flag_bank #(.W(FLT_W), .HELD(FLT_HELD)) u_flt_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (flt_evt),
      .cond  (flt_cond),
      .rd    (rd_flt),
      .flags (flt_flags)
   );

   stat_irq_flag_bank #(.W(STS_W), .HELD(STS_HELD)) u_sts_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (sts_evt),
      .cond  (sts_cond),
      .rd    (rd_sts),
      .flags (sts_flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         glb_q <= 1'b0;
      else if (any_evt)
         glb_q <= 1'b1;
      else if (rd_glb)
         glb_q <= 1'b0;
   end
   assign glb_irq = glb_q;

   stat_irq_pulse_seq #(.TICKS(TICKS_PER_PHASE)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .start      (seq_start),
      .chg_active (chg_active),
      .phase      (seq_phase),
      .busy       (seq_busy)
   );

   always_comb begin
      case (seq_phase)
         PH_NOTCH: stat_pull = 1'b0;
         PH_LOW:   stat_pull = 1'b1;
         default:  stat_pull = chg_active;
      endcase
   end
endmodule

// File: rtl/stat_irq_pulser_chk.sv
module stat_irq_pulser_chk #(
   parameter int unsigned FLT_W = 8,
   parameter int unsigned STS_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chg_active,
   input logic [FLT_W-1:0] flt_evt,
   input logic [FLT_W-1:0] flt_mask,
   input logic [STS_W-1:0] sts_evt,
   input logic [STS_W-1:0] sts_mask,
   input logic             stat_pull,
   input logic [FLT_W-1:0] flt_flags,
   input logic [STS_W-1:0] sts_flags,
   input logic             glb_irq,
   input logic             seq_busy
);
   logic unm;
   assign unm = (|(flt_evt & ~flt_mask)) | (|(sts_evt & ~sts_mask));

   AST_IDLE_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_busy |-> (stat_pull == chg_active)); // R1

   AST_GLB_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_busy ##1 seq_busy) |-> glb_irq); // R4

   AST_EVT_SETS_GLB: assert property (@(posedge clk) disable iff (!rst_n)
      ((|flt_evt) || (|sts_evt)) |=> glb_irq); // R4

   AST_MASKED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!unm && !seq_busy) |=> !seq_busy); // R5

   AST_GLB_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_irq && !seq_busy) |=> !seq_busy); // R6

   AST_FLT_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|flt_evt) |=> ((flt_flags & $past(flt_evt)) == $past(flt_evt))); // R9

   AST_STS_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|sts_evt) |=> ((sts_flags & $past(sts_evt)) == $past(sts_evt))); // R9
endmodule

bind stat_irq_pulser stat_irq_pulser_chk #(.FLT_W(FLT_W), .STS_W(STS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chg_active (chg_active),
   .flt_evt    (flt_evt),
   .flt_mask   (flt_mask),
   .sts_evt    (sts_evt),
   .sts_mask   (sts_mask),
   .stat_pull  (stat_pull),
   .flt_flags  (flt_flags),
   .sts_flags  (sts_flags),
   .glb_irq    (glb_irq),
   .seq_busy   (seq_busy)
);

// File: tb/test_stat_irq_pulser.sv
`timescale 1ns/1ps
module test_stat_irq_pulser;
   localparam int TPP = 16;
   localparam int TICK_DIV = 8;
   localparam logic [7:0] FH = 8'h84;
   localparam logic [2:0] SH = 3'b010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic chg_active = 1'b0;
   logic [7:0] flt_evt = '0, flt_cond = '0, flt_mask = '0;
   logic [2:0] sts_evt = '0, sts_cond = '0, sts_mask = '0;
   logic rd_flt = 1'b0, rd_sts = 1'b0, rd_glb = 1'b0;
   logic stat_pull, glb_irq;
   logic [7:0] flt_flags;
   logic [2:0] sts_flags;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   stat_irq_pulser i_stat_irq_pulser (
      .clk(clk), .rst_n(rst_n), .tick(tick), .chg_active(chg_active),
      .flt_evt(flt_evt), .flt_cond(flt_cond), .flt_mask(flt_mask),
      .sts_evt(sts_evt), .sts_cond(sts_cond), .sts_mask(sts_mask),
      .rd_flt(rd_flt), .rd_sts(rd_sts), .rd_glb(rd_glb),
      .stat_pull(stat_pull), .flt_flags(flt_flags), .sts_flags(sts_flags),
      .glb_irq(glb_irq)
   );

   // time base: one tick every TICK_DIV cycles, driven at negedge
   int tdiv = 0;
   always @(negedge clk) begin
      tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      tick = (tdiv == 0);
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // behavioural reference model: phase 0 idle, 1 notch, 2 low
   int m_phase = 0;
   int m_cnt = 0;
   logic [7:0] m_flt = '0;
   logic [2:0] m_sts = '0;
   logic m_glb = 1'b0;
   int model_fail_prints = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_flt = '0; m_sts = '0; m_glb = 1'b0;
      end else begin
         bit unm, anye;
         unm  = ((flt_evt & ~flt_mask) != 0) || ((sts_evt & ~sts_mask) != 0);
         anye = (flt_evt != 0) || (sts_evt != 0);
         if (m_phase == 0) begin
            if (unm && !m_glb) begin
               m_phase = chg_active ? 1 : 2;
               m_cnt = 0;
            end
         end else if (tick) begin
            if (m_cnt == TPP - 1) begin
               m_cnt = 0;
               m_phase = (m_phase == 1) ? 2 : 0;
            end else m_cnt++;
         end
         for (int i = 0; i < 8; i++) begin
            if (rd_flt && !(FH[i] && flt_cond[i])) m_flt[i] = 1'b0;
            if (flt_evt[i]) m_flt[i] = 1'b1;
         end
         for (int i = 0; i < 3; i++) begin
            if (rd_sts && !(SH[i] && sts_cond[i])) m_sts[i] = 1'b0;
            if (sts_evt[i]) m_sts[i] = 1'b1;
         end
         if (rd_glb) m_glb = 1'b0;
         if (anye) m_glb = 1'b1;
      end
   end

   // cycle-by-cycle comparison, 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         logic exp_pull;
         exp_pull = (m_phase == 2) ? 1'b1 : (m_phase == 1) ? 1'b0 : chg_active;
         checks++;
         if (stat_pull !== exp_pull || flt_flags !== m_flt || sts_flags !== m_sts || glb_irq !== m_glb) begin
            errors++;
            if (model_fail_prints < 20) begin
               model_fail_prints++;
               $display("FAIL R2 model compare pull=%0b/%0b flt=%0h/%0h sts=%0h/%0h glb=%0b/%0b",
                        stat_pull, exp_pull, flt_flags, m_flt, sts_flags, m_sts, glb_irq, m_glb);
            end
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe(input logic [7:0] fe, input logic [2:0] se,
                         input logic rf, input logic rs, input logic rg);
      flt_evt = fe; sts_evt = se; rd_flt = rf; rd_sts = rs; rd_glb = rg;
      @(negedge clk);
      flt_evt = '0; sts_evt = '0; rd_flt = 1'b0; rd_sts = 1'b0; rd_glb = 1'b0;
   endtask

   task automatic clear_all();
      strobe('0, '0, 1'b1, 1'b1, 1'b1);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      step(5);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      check(stat_pull == 1'b0, "R1 reset pin", stat_pull, 0);
      check(flt_flags == 8'h00 && sts_flags == 3'b000, "R1 reset flags", {flt_flags, sts_flags}, 0);
      check(glb_irq == 1'b0, "R1 reset global", glb_irq, 0);

      // R1 static level
      chg_active = 1'b1; step(2);
      check(stat_pull == 1'b1, "R1 charging holds low", stat_pull, 1);
      chg_active = 1'b0; step(2);
      check(stat_pull == 1'b0, "R1 released when idle", stat_pull, 0);

      // R2 plain low pulse on input over-voltage (bit 1)
      strobe(8'h02, '0, 0, 0, 0);
      check(stat_pull == 1'b1, "R2 pulse starts", stat_pull, 1);
      check(flt_flags == 8'h02, "R4 flag recorded", flt_flags, 8'h02);
      check(glb_irq == 1'b1, "R4 global set", glb_irq, 1);
      step(100);
      check(stat_pull == 1'b1, "R2 pulse still low", stat_pull, 1);
      step(40);
      check(stat_pull == 1'b0, "R2 pulse ended", stat_pull, 0);
      strobe('0, '0, 1, 0, 1);
      check(flt_flags == 8'h00, "R7 transient cleared by read", flt_flags, 0);
      check(glb_irq == 1'b0, "R6 global cleared by read", glb_irq, 0);

      // R3 / R10 notch while charging, status bit 0
      chg_active = 1'b1; step(5);
      strobe('0, 3'b001, 0, 0, 0);
      check(stat_pull == 1'b0, "R3 notch released", stat_pull, 0);
      step(50);
      check(stat_pull == 1'b0, "R3 notch still released", stat_pull, 0);
      step(90);
      check(stat_pull == 1'b1, "R3 low after notch", stat_pull, 1);
      chg_active = 1'b0; step(10);
      check(stat_pull == 1'b1, "R10 level change ignored mid-pulse", stat_pull, 1);
      step(130);
      check(stat_pull == 1'b0, "R10 returns to charging level", stat_pull, 0);
      check(sts_flags == 3'b001, "R4 status flag", sts_flags, 3'b001);
      clear_all();
      check(sts_flags == 3'b000, "R7 status cleared", sts_flags, 0);

      // R5 masked event
      flt_mask = 8'hFF; step(2);
      strobe(8'h08, '0, 0, 0, 0);
      check(flt_flags == 8'h08 && glb_irq, "R5 masked event recorded", {flt_flags, glb_irq}, 9'h011);
      step(20);
      check(stat_pull == 1'b0, "R5 no pulse when masked", stat_pull, 0);
      clear_all();
      flt_mask = 8'h00; step(2);

      // R6 global bit blocks pulses
      strobe(8'h01, '0, 0, 0, 0);
      step(300);
      check(glb_irq == 1'b1, "R6 global sticky", glb_irq, 1);
      strobe(8'h20, '0, 0, 0, 0);
      check(flt_flags[5] == 1'b1, "R6 blocked event still flagged", flt_flags[5], 1);
      step(20);
      check(stat_pull == 1'b0, "R6 no pulse while global set", stat_pull, 0);
      strobe('0, '0, 0, 0, 1);
      check(glb_irq == 1'b0, "R6 global read clears", glb_irq, 0);
      strobe(8'h40, '0, 0, 0, 0);
      check(stat_pull == 1'b1, "R6 pulse after global cleared", stat_pull, 1);
      step(300);
      clear_all();

      // R8 held flags: fault bit 7 and status bit 1
      flt_cond[7] = 1'b1; sts_cond[1] = 1'b1;
      strobe(8'h80, 3'b010, 0, 0, 0);
      strobe('0, '0, 1, 1, 0);
      check(flt_flags[7] == 1'b1, "R8 held fault survives read", flt_flags[7], 1);
      check(sts_flags[1] == 1'b1, "R8 held status survives read", sts_flags[1], 1);
      flt_cond[7] = 1'b0; sts_cond[1] = 1'b0; step(3);
      check(flt_flags[7] == 1'b1, "R8 held flag waits for read", flt_flags[7], 1);
      strobe('0, '0, 1, 1, 0);
      check(flt_flags[7] == 1'b0, "R8 held fault clears after condition", flt_flags[7], 0);
      check(sts_flags[1] == 1'b0, "R8 held status clears after condition", sts_flags[1], 0);
      step(300);
      clear_all();

      // R9 event coinciding with read
      strobe(8'h10, 3'b100, 1, 1, 1);
      check(flt_flags[4] == 1'b1, "R9 fault event wins over read", flt_flags[4], 1);
      check(sts_flags[2] == 1'b1, "R9 status event wins over read", sts_flags[2], 1);
      check(glb_irq == 1'b1, "R9 global event wins over read", glb_irq, 1);
      step(300);
      clear_all();
      step(4);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule